// File: doc/BRIEF.md
# Cache Reuse Predictor with PC-Signature Training

This block is the tag side of a set-associative cache with a reuse predictor. Every resident line keeps a valid bit, a tag, a short signature taken from the program counter of its most recent reader, a one-bit bypass flag and a lock bit. A table of saturating counters, one per signature value, learns which instruction signatures bring in lines that die without reuse. A counter falls when a line is reused by a read hit, charged to the signature stored in that line. It rises when a valid line is evicted, charged to that line's signature.

Each request carries an address, a read/write flag and a program counter. The block looks the address up in the indexed set and reports hit or miss one cycle later. On a read miss it either rejects the request (every way of the set locked), bypasses it (the requester's counter has reached a programmable threshold) or fills a way. A side port sets a line's bypass flag, signature or lock, or reads its flag and signature, by address. A peek port reads any counter, so training can be observed.

Top module: `rp_reuse_predictor`

## Requirements
- R1: The low OFF_W address bits are ignored, the next log2(SETS) bits select the set and the remaining upper bits are the tag. A request hits when a valid way of the selected set holds that tag. rsp_valid, rsp_hit, rsp_bypass and rsp_resfail are registered and appear in the cycle after req_valid, with at most one of the three outcome bits set.
- R2: A request's signature is the low SIG_W bits of req_pc. The table holds 2^SIG_W counters of CNT_W bits, indexed directly by signature, and peek_cnt shows the counter selected by peek_sig without delay.
- R3: A read hit decrements the counter at the signature stored in the hit line, and a counter at zero stays at zero.
- R4: After a read hit, the hit line's signature becomes the request's signature.
- R5: A write, hit or miss, never changes a counter, a signature or a line's presence. A write hit reports rsp_hit and makes the line most recently used.
- R6: A read miss in a set whose ways are all locked gives rsp_resfail=1 with rsp_hit=0 and rsp_bypass=0, and changes no line and no counter.
- R7: A read miss that is not rejected, whose own signature's counter is greater than or equal to thresh, gives rsp_bypass=1 and changes no line and no counter.
- R8: Any other read miss fills one way: the lowest-numbered invalid way if one exists, otherwise the least recently used unlocked way. The filled line becomes valid with the request's tag and signature, bypass flag 0, lock 0, and most recently used. Read hits, write hits and fills update recency; side-port operations do not.
- R9: Filling over a valid line increments the counter at that line's signature, saturating at 2^CNT_W-1.
- R10: The side port matches mnt_addr like a request. mnt_op encodes 0 as set the bypass flag to mnt_wdata[0], 1 as set the signature to mnt_wdata, 2 as read only, and 3 as set the lock to mnt_wdata[0]. In the next cycle mnt_rsp_valid=1, and mnt_found tells whether a line matched. mnt_bypass and mnt_sig give that line's values after the operation, or 0 with no change when nothing matched.
- R11: A side-port operation presented in the same cycle as req_valid is dropped: mnt_rsp_valid stays 0 and no line changes.
- R12: After reset every line is invalid and unlocked, every counter is zero, and rsp_valid and mnt_rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Request byte address |
| req_pc | input | PC_W | Program counter of the requester |
| thresh | input | CNT_W | Bypass threshold for read misses |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Request hit |
| rsp_bypass | output | 1 | Read miss served without allocation |
| rsp_resfail | output | 1 | Read miss rejected, set fully locked |
| mnt_valid | input | 1 | Side-port operation present |
| mnt_op | input | 2 | Side-port operation code |
| mnt_addr | input | ADDR_W | Address selecting the line |
| mnt_wdata | input | SIG_W | New signature, or flag value in bit 0 |
| mnt_rsp_valid | output | 1 | Side-port result for the previous cycle |
| mnt_found | output | 1 | A line matched the address |
| mnt_bypass | output | 1 | Line's bypass flag after the operation |
| mnt_sig | output | SIG_W | Line's signature after the operation |
| peek_sig | input | SIG_W | Counter index to observe |
| peek_cnt | output | CNT_W | Value of the observed counter |

## Verification
The bench builds the block with 16-bit addresses, 4 sets of 2 ways, 4-bit signatures and 3-bit counters. Two fills therefore fill a set, so eviction, the recency order and a fully locked set each take only a few requests. A counter reaches its ceiling of 7 after seven evictions, which puts saturation and threshold bypass in reach of a short stream. With only 16 counters the bench can compare the whole table against its reference model after every scenario.

// File: rtl/rp_pkg.sv
package rp_pkg;

  // Side-port operation codes
  typedef enum logic [1:0] {
    MNT_SET_BYP  = 2'd0,
    MNT_SET_SIG  = 2'd1,
    MNT_READ     = 2'd2,
    MNT_SET_LOCK = 2'd3
  } mnt_op_e;

endpackage

// File: rtl/rp_counter_table.sv
module rp_counter_table #(
  parameter int SIG_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             upd_up,
  input  logic [SIG_W-1:0] upd_idx,
  input  logic [SIG_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_val,
  input  logic [SIG_W-1:0] peek_idx,
  output logic [CNT_W-1:0] peek_val
);

  localparam int ENTRIES = 1 << SIG_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q [ENTRIES];

  // Saturating step: up stops at CMAX, down stops at zero
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] v,
                                                input logic up);
    if (up) return (v == CMAX) ? v : v + 1'b1;
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= '0;
    end else if (upd_en) begin
      cnt_q[upd_idx] <= cnt_step(cnt_q[upd_idx], upd_up);
    end
  end

  assign rd_val   = cnt_q[rd_idx];
  assign peek_val = cnt_q[peek_idx];

  // R3: decrement at zero keeps zero
  p_floor_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_up && cnt_q[upd_idx] == '0) |=> cnt_q[$past(upd_idx)] == '0);

  // R9: increment at the ceiling keeps the ceiling
  p_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_up && cnt_q[upd_idx] == CMAX) |=> cnt_q[$past(upd_idx)] == CMAX);

  // R9: a non-saturated increment moves by exactly one
  p_inc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_up && cnt_q[upd_idx] != CMAX)
      |=> cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) + 1'b1);

endmodule

// File: rtl/rp_victim_pick.sv
module rp_victim_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS-1:0]       way_lock,
  input  logic [WAYS*WAY_W-1:0] way_age,
  output logic [WAY_W-1:0]      pick_way,
  output logic                  pick_ok,
  output logic                  pick_valid
);

  logic             inv_ok, lru_ok;
  logic [WAY_W-1:0] inv_way, lru_way, best_age;

  // Lowest invalid way first; otherwise oldest unlocked valid way
  always_comb begin
    inv_ok   = 1'b0;
    inv_way  = '0;
    lru_ok   = 1'b0;
    lru_way  = '0;
    best_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!way_valid[w] && !way_lock[w] && !inv_ok) begin
        inv_ok  = 1'b1;
        inv_way = WAY_W'(w);
      end
      if (way_valid[w] && !way_lock[w] &&
          (!lru_ok || way_age[w*WAY_W +: WAY_W] > best_age)) begin
        lru_ok   = 1'b1;
        lru_way  = WAY_W'(w);
        best_age = way_age[w*WAY_W +: WAY_W];
      end
    end
    pick_ok    = inv_ok || lru_ok;
    pick_way   = inv_ok ? inv_way : lru_way;
    pick_valid = !inv_ok && lru_ok;
  end

endmodule

// File: rtl/rp_tag_store.sv
module rp_tag_store
  import rp_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  parameter int SIG_W = 8,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  // request lookup
  input  logic [SET_W-1:0]      lk_set,
  input  logic [TAG_W-1:0]      lk_tag,
  output logic                  lk_hit,
  output logic [WAY_W-1:0]      lk_way,
  output logic [SIG_W-1:0]      lk_sig,
  output logic [WAYS-1:0]       set_valid,
  output logic [WAYS-1:0]       set_lock,
  output logic [WAYS*WAY_W-1:0] set_age,
  output logic [WAYS*SIG_W-1:0] set_sig,
  // side-port lookup
  input  logic [SET_W-1:0]      mt_set,
  input  logic [TAG_W-1:0]      mt_tag,
  output logic                  mt_hit,
  output logic [WAY_W-1:0]      mt_way,
  output logic                  mt_byp,
  output logic [SIG_W-1:0]      mt_sig,
  // request update
  input  logic                  acc_en,
  input  logic [WAY_W-1:0]      acc_way,
  input  logic                  acc_fill,
  input  logic                  acc_sig_wr,
  input  logic [SIG_W-1:0]      acc_sig,
  // side-port update
  input  logic                  mt_en,
  input  mnt_op_e               mt_op,
  input  logic [SIG_W-1:0]      mt_data
);

  logic             valid_q [SETS][WAYS];
  logic             lock_q  [SETS][WAYS];
  logic             byp_q   [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [SIG_W-1:0] sig_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];

  logic [WAYS-1:0] hit_vec, mhit_vec;

  // Recency: the touched way becomes 0, younger ways age by one
  function automatic logic [WAY_W-1:0] age_next(input logic [WAY_W-1:0] cur,
                                                input logic [WAY_W-1:0] hit_age,
                                                input logic touched);
    if (touched) return '0;
    return (cur < hit_age) ? cur + 1'b1 : cur;
  endfunction

  function automatic logic [WAY_W-1:0] first_one(input logic [WAYS-1:0] v);
    for (int w = 0; w < WAYS; w++) if (v[w]) return WAY_W'(w);
    return '0;
  endfunction

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign hit_vec[g]  = valid_q[lk_set][g] && (tag_q[lk_set][g] == lk_tag);
    assign mhit_vec[g] = valid_q[mt_set][g] && (tag_q[mt_set][g] == mt_tag);
    assign set_valid[g] = valid_q[lk_set][g];
    assign set_lock[g]  = lock_q[lk_set][g];
    assign set_age[g*WAY_W +: WAY_W] = age_q[lk_set][g];
    assign set_sig[g*SIG_W +: SIG_W] = sig_q[lk_set][g];
  end

  assign lk_hit = |hit_vec;
  assign lk_way = first_one(hit_vec);
  assign lk_sig = sig_q[lk_set][lk_way];
  assign mt_hit = |mhit_vec;
  assign mt_way = first_one(mhit_vec);
  assign mt_byp = byp_q[mt_set][mt_way];
  assign mt_sig = sig_q[mt_set][mt_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          lock_q[s][w]  <= 1'b0;
          byp_q[s][w]   <= 1'b0;
          tag_q[s][w]   <= '0;
          sig_q[s][w]   <= '0;
          age_q[s][w]   <= WAY_W'(w);
        end
      end
    end else if (acc_en) begin
      for (int w = 0; w < WAYS; w++) begin
        age_q[lk_set][w] <= age_next(age_q[lk_set][w], age_q[lk_set][acc_way],
                                     WAY_W'(w) == acc_way);
      end
      if (acc_fill) begin
        valid_q[lk_set][acc_way] <= 1'b1;
        tag_q[lk_set][acc_way]   <= lk_tag;
        sig_q[lk_set][acc_way]   <= acc_sig;
        byp_q[lk_set][acc_way]   <= 1'b0;
        lock_q[lk_set][acc_way]  <= 1'b0;
      end else if (acc_sig_wr) begin
        sig_q[lk_set][acc_way] <= acc_sig;
      end
    end else if (mt_en && mt_hit) begin
      case (mt_op)
        MNT_SET_BYP:  byp_q[mt_set][mt_way]  <= mt_data[0];
        MNT_SET_SIG:  sig_q[mt_set][mt_way]  <= mt_data;
        MNT_SET_LOCK: lock_q[mt_set][mt_way] <= mt_data[0];
        default: ;
      endcase
    end
  end

  // R1: a tag lives in at most one way of a set
  p_unique_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6: a locked line is never overwritten by a fill
  p_fill_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_fill) |-> !lock_q[lk_set][acc_way]);

  // R8: a filled or touched way reads back as most recent
  p_touch_recent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> age_q[$past(lk_set)][$past(acc_way)] == '0);

endmodule

// File: rtl/rp_reuse_predictor.sv
module rp_reuse_predictor
  import rp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int OFF_W  = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int SIG_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [CNT_W-1:0]  thresh,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_bypass,
  output logic              rsp_resfail,
  input  logic              mnt_valid,
  input  logic [1:0]        mnt_op,
  input  logic [ADDR_W-1:0] mnt_addr,
  input  logic [SIG_W-1:0]  mnt_wdata,
  output logic              mnt_rsp_valid,
  output logic              mnt_found,
  output logic              mnt_bypass,
  output logic [SIG_W-1:0]  mnt_sig,
  input  logic [SIG_W-1:0]  peek_sig,
  output logic [CNT_W-1:0]  peek_cnt
);

  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [SIG_W-1:0] pc_sig(input logic [PC_W-1:0] pc);
    return pc[SIG_W-1:0];
  endfunction

  logic unused_bits;
  assign unused_bits = ^{req_addr[OFF_W-1:0], mnt_addr[OFF_W-1:0], req_pc};

  mnt_op_e mop;
  assign mop = mnt_op_e'(mnt_op);

  // Tag store
  logic                  lk_hit, mt_hit, mt_byp;
  logic [WAY_W-1:0]      lk_way, mt_way;
  logic [SIG_W-1:0]      lk_sig, mt_sig;
  logic [WAYS-1:0]       set_valid, set_lock;
  logic [WAYS*WAY_W-1:0] set_age;
  logic [WAYS*SIG_W-1:0] set_sig;
  logic                  acc_en, acc_fill, acc_sig_wr, mt_en;
  logic [WAY_W-1:0]      acc_way;
  logic [SIG_W-1:0]      req_sig;

  // Victim
  logic [WAY_W-1:0] vict_way;
  logic             vict_ok, vict_valid;
  logic [SIG_W-1:0] vict_sig;

  // Counter table
  logic             tbl_en, tbl_up;
  logic [SIG_W-1:0] tbl_idx;
  logic [CNT_W-1:0] req_cnt;

  // Named events
  logic ev_rd, ev_rd_hit, ev_rd_miss, ev_resfail, ev_bypass, ev_fill, ev_evict, ev_wr_hit;

  assign req_sig  = pc_sig(req_pc);
  assign vict_sig = set_sig[vict_way*SIG_W +: SIG_W];

  assign ev_rd      = req_valid && !req_write;
  assign ev_rd_hit  = ev_rd && lk_hit;
  assign ev_rd_miss = ev_rd && !lk_hit;
  assign ev_resfail = ev_rd_miss && !vict_ok;
  assign ev_bypass  = ev_rd_miss && vict_ok && (req_cnt >= thresh);
  assign ev_fill    = ev_rd_miss && vict_ok && !(req_cnt >= thresh);
  assign ev_evict   = ev_fill && vict_valid;
  assign ev_wr_hit  = req_valid && req_write && lk_hit;

  assign tbl_en  = ev_rd_hit || ev_evict;
  assign tbl_up  = ev_evict;
  assign tbl_idx = ev_rd_hit ? lk_sig : vict_sig;

  assign acc_en     = ev_rd_hit || ev_wr_hit || ev_fill;
  assign acc_way    = ev_fill ? vict_way : lk_way;
  assign acc_fill   = ev_fill;
  assign acc_sig_wr = ev_rd_hit;
  assign mt_en      = mnt_valid && !req_valid;

  rp_tag_store #(
    .SETS (SETS), .WAYS (WAYS), .TAG_W (TAG_W), .SIG_W (SIG_W),
    .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (addr_set(req_addr)),
    .lk_tag    (addr_tag(req_addr)),
    .lk_hit    (lk_hit),
    .lk_way    (lk_way),
    .lk_sig    (lk_sig),
    .set_valid (set_valid),
    .set_lock  (set_lock),
    .set_age   (set_age),
    .set_sig   (set_sig),
    .mt_set    (addr_set(mnt_addr)),
    .mt_tag    (addr_tag(mnt_addr)),
    .mt_hit    (mt_hit),
    .mt_way    (mt_way),
    .mt_byp    (mt_byp),
    .mt_sig    (mt_sig),
    .acc_en    (acc_en),
    .acc_way   (acc_way),
    .acc_fill  (acc_fill),
    .acc_sig_wr(acc_sig_wr),
    .acc_sig   (req_sig),
    .mt_en     (mt_en),
    .mt_op     (mop),
    .mt_data   (mnt_wdata)
  );

  rp_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .way_valid (set_valid),
    .way_lock  (set_lock),
    .way_age   (set_age),
    .pick_way  (vict_way),
    .pick_ok   (vict_ok),
    .pick_valid(vict_valid)
  );

  rp_counter_table #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (tbl_en),
    .upd_up  (tbl_up),
    .upd_idx (tbl_idx),
    .rd_idx  (req_sig),
    .rd_val  (req_cnt),
    .peek_idx(peek_sig),
    .peek_val(peek_cnt)
  );

  // Side-port result after the operation
  logic             mt_byp_new;
  logic [SIG_W-1:0] mt_sig_new;
  assign mt_byp_new = (mop == MNT_SET_BYP) ? mnt_wdata[0] : mt_byp;
  assign mt_sig_new = (mop == MNT_SET_SIG) ? mnt_wdata : mt_sig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_bypass    <= 1'b0;
      rsp_resfail   <= 1'b0;
      mnt_rsp_valid <= 1'b0;
      mnt_found     <= 1'b0;
      mnt_bypass    <= 1'b0;
      mnt_sig       <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_hit       <= req_valid && lk_hit;
      rsp_bypass    <= ev_bypass;
      rsp_resfail   <= ev_resfail;
      mnt_rsp_valid <= mt_en;
      mnt_found     <= mt_en && mt_hit;
      mnt_bypass    <= mt_en && mt_hit && mt_byp_new;
      mnt_sig       <= (mt_en && mt_hit) ? mt_sig_new : '0;
    end
  end

  // R1: one response per request, in the next cycle
  p_resp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_hit, rsp_bypass, rsp_resfail}));

  // R5: writes never train the table
  p_write_no_train_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> !tbl_en);

  // R6: a fully locked set rejects a read miss
  p_resfail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !lk_hit && set_lock == '1)
      |=> rsp_resfail && !rsp_hit && !rsp_bypass);

  // R7: counter at or above threshold bypasses
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !lk_hit && set_lock != '1 && req_cnt >= thresh)
      |=> rsp_bypass && !rsp_hit);

  // R8: the chosen victim is never locked
  p_victim_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |-> !set_lock[vict_way]);

  // R11: a colliding side-port operation is dropped
  p_mnt_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_valid && req_valid) |=> !mnt_rsp_valid);

endmodule

// File: tb/rp_reuse_predictor_tb.sv
module rp_reuse_predictor_tb;

  localparam int AW = 16, PW = 16, OW = 4, NS = 4, NW = 2, SW = 4, CW = 3;
  localparam int NSIG = 1 << SW;
  localparam int CTOP = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [PW-1:0] req_pc = '0;
  logic [CW-1:0] thresh = 3'd7;
  logic rsp_valid, rsp_hit, rsp_bypass, rsp_resfail;
  logic mnt_valid = 1'b0;
  logic [1:0] mnt_op = 2'd2;
  logic [AW-1:0] mnt_addr = '0;
  logic [SW-1:0] mnt_wdata = '0;
  logic mnt_rsp_valid, mnt_found, mnt_bypass;
  logic [SW-1:0] mnt_sig;
  logic [SW-1:0] peek_sig = '0;
  logic [CW-1:0] peek_cnt;

  always #4 clk = ~clk;

  rp_reuse_predictor #(
    .ADDR_W(AW), .PC_W(PW), .OFF_W(OW), .SETS(NS), .WAYS(NW), .SIG_W(SW), .CNT_W(CW)
  ) u_dut (.*);

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // Reference model
  bit mv [NS][NW];
  bit ml [NS][NW];
  bit mb [NS][NW];
  int mt [NS][NW];
  int ms [NS][NW];
  int mst[NS][NW];
  int mc [NSIG];
  int now = 0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkaddr(input int tg, input int st);
    return AW'((tg << (OW + 2)) | (st << OW) | 3);
  endfunction

  function automatic int find_way(input int tg, input int st);
    for (int w = 0; w < NW; w++) if (mv[st][w] && mt[st][w] == tg) return w;
    return -1;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 0; ml[s][w] = 0; mb[s][w] = 0; mt[s][w] = 0; ms[s][w] = 0;
        mst[s][w] = -w;
      end
    for (int i = 0; i < NSIG; i++) mc[i] = 0;
    now = 0;
  endtask

  // Model one request, return expected outcome bits
  task automatic model_req(input bit wr, input int tg, input int st, input int pc,
                           output int e_hit, output int e_byp, output int e_rf);
    int hw, ps, vw;
    hw = find_way(tg, st);
    ps = pc % NSIG;
    e_hit = 0; e_byp = 0; e_rf = 0;
    now++;
    if (hw >= 0) begin
      e_hit = 1;
      mst[st][hw] = now;
      if (!wr) begin
        if (mc[ms[st][hw]] > 0) mc[ms[st][hw]]--;
        ms[st][hw] = ps;
      end
    end else if (!wr) begin
      vw = -1;
      for (int w = 0; w < NW; w++) if (!mv[st][w] && !ml[st][w] && vw < 0) vw = w;
      if (vw < 0)
        for (int w = 0; w < NW; w++)
          if (!ml[st][w] && (vw < 0 || mst[st][w] < mst[st][vw])) vw = w;
      if (vw < 0) e_rf = 1;
      else if (mc[ps] >= int'(thresh)) e_byp = 1;
      else begin
        if (mv[st][vw] && mc[ms[st][vw]] < CTOP) mc[ms[st][vw]]++;
        mv[st][vw] = 1; mt[st][vw] = tg; ms[st][vw] = ps;
        mb[st][vw] = 0; ml[st][vw] = 0; mst[st][vw] = now;
      end
    end
  endtask

  task automatic do_req(input bit wr, input int tg, input int st, input int pc, input string rq);
    int e_hit, e_byp, e_rf;
    model_req(wr, tg, st, pc, e_hit, e_byp, e_rf);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = mkaddr(tg, st); req_pc = PW'(pc);
    @(negedge clk);
    req_valid = 0;
    chk(rq, "rsp_valid", int'(rsp_valid), 1);
    chk(rq, "rsp_hit", int'(rsp_hit), e_hit);
    chk(rq, "rsp_bypass", int'(rsp_bypass), e_byp);
    chk(rq, "rsp_resfail", int'(rsp_resfail), e_rf);
  endtask

  task automatic model_mnt(input int op, input int tg, input int st, input int data,
                           output int e_f, output int e_b, output int e_s);
    int hw;
    hw = find_way(tg, st);
    e_f = 0; e_b = 0; e_s = 0;
    if (hw >= 0) begin
      case (op)
        0: mb[st][hw] = data[0];
        1: ms[st][hw] = data % NSIG;
        3: ml[st][hw] = data[0];
        default: ;
      endcase
      e_f = 1; e_b = int'(mb[st][hw]); e_s = ms[st][hw];
    end
  endtask

  task automatic do_mnt(input int op, input int tg, input int st, input int data, input string rq);
    int e_f, e_b, e_s;
    model_mnt(op, tg, st, data, e_f, e_b, e_s);
    @(negedge clk);
    mnt_valid = 1; mnt_op = 2'(op); mnt_addr = mkaddr(tg, st); mnt_wdata = SW'(data);
    @(negedge clk);
    mnt_valid = 0;
    chk(rq, "mnt_rsp_valid", int'(mnt_rsp_valid), 1);
    chk(rq, "mnt_found", int'(mnt_found), e_f);
    chk(rq, "mnt_bypass", int'(mnt_bypass), e_b);
    chk(rq, "mnt_sig", int'(mnt_sig), e_s);
  endtask

  task automatic chk_cnt(input string rq);
    for (int i = 0; i < NSIG; i++) begin
      peek_sig = SW'(i);
      #1;
      chk(rq, $sformatf("counter[%0d]", i), int'(peek_cnt), mc[i]);
    end
  endtask

  // Scenarios
  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk("R12", "rsp_valid", int'(rsp_valid), 0);
    chk("R12", "mnt_rsp_valid", int'(mnt_rsp_valid), 0);
    chk_cnt("R12");
    do_mnt(2, 5, 0, 0, "R12");
  endtask

  task automatic t_fill_hit();
    thresh = 3'd7;
    do_req(0, 5, 0, 'h13, "R8");
    do_mnt(2, 5, 0, 0, "R8");
    do_req(0, 5, 0, 'h25, "R3");
    do_mnt(2, 5, 0, 0, "R4");
    do_req(0, 5, 1, 'h0B, "R1");
    do_req(0, 5, 1, 'h0B, "R1");
    chk_cnt("R3");
    chk_cnt("R2");
  endtask

  task automatic t_write();
    do_req(1, 9, 0, 'h07, "R5");
    do_mnt(2, 9, 0, 0, "R5");
    do_req(1, 5, 0, 'h0A, "R5");
    do_mnt(2, 5, 0, 0, "R5");
    chk_cnt("R5");
  endtask

  task automatic t_lru();
    do_req(0, 1, 2, 1, "R8");
    do_req(0, 2, 2, 2, "R8");
    do_req(1, 1, 2, 9, "R5");
    do_req(0, 3, 2, 3, "R9");
    do_mnt(2, 2, 2, 0, "R8");
    do_mnt(2, 1, 2, 0, "R8");
    chk_cnt("R9");
  endtask

  task automatic t_saturate();
    thresh = 3'd7;
    for (int i = 0; i < 20; i++) do_req(0, 100 + i, 3, (i % 2) ? 7 : 6, "R9");
    chk_cnt("R9");
  endtask

  task automatic t_bypass();
    thresh = 3'd1;
    do_req(0, 50, 0, 2, "R7");
    do_mnt(2, 50, 0, 0, "R7");
    thresh = 3'd0;
    do_req(0, 51, 0, 'hF, "R7");
    do_mnt(2, 51, 0, 0, "R7");
    chk_cnt("R7");
    thresh = 3'd7;
  endtask

  task automatic t_lock();
    do_req(0, 6, 1, 4, "R8");
    do_mnt(3, 5, 1, 1, "R10");
    do_mnt(3, 6, 1, 1, "R10");
    do_req(0, 7, 1, 8, "R6");
    do_mnt(2, 7, 1, 0, "R6");
    chk_cnt("R6");
    do_mnt(3, 6, 1, 0, "R10");
    do_req(0, 7, 1, 8, "R8");
    do_mnt(2, 5, 1, 0, "R8");
    do_mnt(2, 6, 1, 0, "R8");
    chk_cnt("R9");
  endtask

  task automatic t_mnt();
    do_mnt(0, 5, 0, 1, "R10");
    do_mnt(1, 5, 0, 6, "R10");
    do_req(0, 5, 0, 'h20, "R3");
    do_mnt(2, 5, 0, 0, "R4");
    do_mnt(0, 77, 2, 1, "R10");
    chk_cnt("R3");
  endtask

  task automatic t_collide();
    int e_hit, e_byp, e_rf;
    model_req(0, 5, 0, 1, e_hit, e_byp, e_rf);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = mkaddr(5, 0); req_pc = 16'h0001;
    mnt_valid = 1; mnt_op = 2'd1; mnt_addr = mkaddr(5, 0); mnt_wdata = 4'd3;
    @(negedge clk);
    req_valid = 0; mnt_valid = 0;
    chk("R11", "rsp_hit", int'(rsp_hit), e_hit);
    chk("R11", "mnt_rsp_valid", int'(mnt_rsp_valid), 0);
    do_mnt(2, 5, 0, 0, "R11");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 0) thresh = CW'($urandom_range(2, 7));
      do_req($urandom_range(0, 3) == 0, $urandom_range(0, 5), $urandom_range(0, 3),
             $urandom_range(0, 31), "R8");
    end
    for (int t = 0; t < 6; t++)
      for (int s = 0; s < NS; s++) do_mnt(2, t, s, 0, "R10");
    chk_cnt("R9");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    model_reset();
    t_reset();
    t_fill_hit();
    t_write();
    t_lru();
    t_saturate();
    t_bypass();
    t_lock();
    t_mnt();
    t_collide();
    t_random();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule